// File: doc/BRIEF.md
# Refresh Interval Timer

This block paces memory refresh. A free-running prescaler divides the bus clock and produces a one-cycle count tick at a rate set by a 3-bit select field. An 8-bit interval counter advances on each tick. When it reaches the value held in the interval constant register, the counter returns to zero on the following tick, so matches recur at a fixed period. Each match sets a sticky flag in the control/status register. An interrupt output is raised while both that flag and its enable bit are 1.

Software reaches the three registers through a plain synchronous register port. A write takes effect at the clock edge on which `bus_we` is high. The read data path is combinational and always reflects the register selected by `bus_addr`. The block has no streaming interface, so it needs no valid/ready handshake and no back-pressure rules. It does not issue refresh commands and does not arbitrate for the memory bus.

Top module: `rfsh_interval_timer`

## Requirements
- R1: In the control/status register (address 0), bits 15..8 always read as 0. In the count register (address 1) and the constant register (address 2), bits 15..8 also always read as 0, because those registers hold only 8 bits.
- R2: After reset, every register reads 0, `irq` is 0, and the counter does not advance.
- R3: The select field sits in bits 5..3 of address 0. Codes 1 to 7 divide the bus clock by 4, 16, 64, 256, 1024, 2048 and 4096. With constant C and divide ratio D, successive flag sets are exactly (C+1)*D bus cycles apart.
- R4: Select code 0 stops counting. The count value then holds.
- R5: The flag sits in bit 7 of address 0. Hardware sets it once each time the count becomes equal to the constant, and it stays set until software clears it.
- R6: Writing address 0 with bit 7 at 0 clears the flag. Writing bit 7 as 1 leaves the flag's value unchanged.
- R7: When a hardware set and a software clear of the flag fall on the same clock edge, the flag ends up set.
- R8: `irq` is high exactly while the flag and the enable bit (bit 6 of address 0) are both 1.
- R9: Bits 2..0 of address 0 are plain read/write storage with reset value 0.
- R10: Software can write the count register directly. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 control/status, 1 count, 2 constant |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register |
| irq | output | 1 | Compare-match interrupt request |

## Verification
The assertions assume that `bus_addr`, `bus_we` and `bus_wdata` are always known values, and that at most one write lands per cycle. Under those assumptions, the only ways the count can change are a tick step, a wrap to zero, or a direct write. The bench drives every input from tasks on the falling edge, so each input is stable across the sampling edge. It keeps `bus_addr` at a defined register whenever it is idle. Its random trials use only the faster divide ratios, so that a clearing write always completes well before the next hardware set.

// File: rtl/rit_pkg.sv
package rit_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CONST = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // Number of low divider bits that must all be one for a tick under a given select code
  function automatic int unsigned stage_bits(input logic [2:0] code);
    case (code)
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 6;
      3'd4:    return 8;
      3'd5:    return 10;
      3'd6:    return 11;
      3'd7:    return 12;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/rit_prescaler.sv
module rit_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  output logic       tick
);
  import rit_pkg::*;

  logic [PRE_W-1:0] div_q;
  logic [PRE_W:0]   mask_w;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  always_comb begin
    mask_w = ({{PRE_W{1'b0}}, 1'b1} << stage_bits(sel)) - 1'b1;
    mask   = mask_w[PRE_W-1:0];
    tick   = (sel != 3'd0) && ((div_q & mask) == mask);
  end
endmodule

// File: rtl/rit_counter.sv
module rit_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_cnt,
  input  logic             wr_cor,
  input  logic [CNT_W-1:0] wval,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cor,
  output logic             match_evt
);
  logic eq, eq_q, upd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (wr_cnt) begin
      cnt <= wval;
    end else if (tick) begin
      cnt <= (cnt == cor) ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cor <= '0;
    else if (wr_cor) cor <= wval;
  end

  assign eq = (cnt == cor);

  // eq_q resets high so the equal-at-reset state raises no event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eq_q  <= 1'b1;
      upd_q <= 1'b0;
    end else begin
      eq_q  <= eq;
      upd_q <= tick | wr_cnt;
    end
  end

  // one event per equality: a fresh equality, or a reload that lands on the constant again
  assign match_evt = eq && (!eq_q || upd_q);
endmodule

// File: rtl/rit_ctrl.sv
module rit_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [7:0]  wval,
  input  logic        match_evt,
  output logic        flag,
  output logic        ie,
  output logic [2:0]  cks,
  output logic [2:0]  spare
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (match_evt) begin
      flag <= 1'b1;
    end else if (wr && !wval[7]) begin
      flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie    <= 1'b0;
      cks   <= 3'd0;
      spare <= 3'd0;
    end else if (wr) begin
      ie    <= wval[6];
      cks   <= wval[5:3];
      spare <= wval[2:0];
    end
  end
endmodule

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import rit_pkg::*;

  localparam int PAD_W = DATA_W - CNT_W;

  logic             tick, match_evt;
  logic             flag_q, ie_q;
  logic [2:0]       cks_q, spare_q;
  logic [CNT_W-1:0] cnt_q, cor_q;
  logic             wr_ctrl, wr_cnt, wr_cor;

  assign wr_ctrl = bus_we && (bus_addr == SEL_CTRL);
  assign wr_cnt  = bus_we && (bus_addr == SEL_COUNT);
  assign wr_cor  = bus_we && (bus_addr == SEL_CONST);

  rit_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .sel(cks_q), .tick(tick)
  );

  rit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_cnt(wr_cnt), .wr_cor(wr_cor),
    .wval(bus_wdata[CNT_W-1:0]), .cnt(cnt_q), .cor(cor_q), .match_evt(match_evt)
  );

  rit_ctrl u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(wr_ctrl), .wval(bus_wdata[7:0]),
    .match_evt(match_evt), .flag(flag_q), .ie(ie_q), .cks(cks_q), .spare(spare_q)
  );

  always_comb begin
    case (bus_addr)
      SEL_CTRL:  bus_rdata = {{(DATA_W-8){1'b0}}, flag_q, ie_q, cks_q, spare_q};
      SEL_COUNT: bus_rdata = {{PAD_W{1'b0}}, cnt_q};
      SEL_CONST: bus_rdata = {{PAD_W{1'b0}}, cor_q};
      default:   bus_rdata = '0;
    endcase
  end

  assign irq = flag_q & ie_q;
endmodule

// File: rtl/rit_checker.sv
module rit_checker #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic              flag,
  input logic              ie,
  input logic [2:0]        cks,
  input logic [CNT_W-1:0]  cnt,
  input logic              evt
);
  logic clr_wr, cnt_wr;
  assign clr_wr = bus_we && (bus_addr == 2'd0) && !bus_wdata[7];
  assign cnt_wr = bus_we && (bus_addr == 2'd1);

  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> (bus_rdata[DATA_W-1:8] == '0));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1) || cnt == '0));

  p_hold_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cks == 3'd0 && !cnt_wr) |=> (cnt == $past(cnt)));

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_wr) |=> flag);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !evt) |=> !flag);

  p_hw_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag);

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (flag && ie));
endmodule

bind rfsh_interval_timer rit_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
  .flag(flag_q), .ie(ie_q), .cks(cks_q), .cnt(cnt_q), .evt(match_evt)
);

// File: tb/sim_rfsh_interval_timer.sv
module sim_rfsh_interval_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rfsh_interval_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic int divide_of(input int code);
    case (code)
      1: return 4;     2: return 16;    3: return 64;   4: return 256;
      5: return 1024;  6: return 2048;  7: return 4096; default: return 0;
    endcase
  endfunction

  function automatic int period_of(input int code, input int cor);
    return (cor + 1) * divide_of(code);
  endfunction

  function automatic logic [15:0] ctrl_word(input bit ie, input int code, input int low);
    return {8'h00, 1'b0, ie, code[2:0], low[2:0]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
    bus_addr = 2'd0;
  endtask

  task automatic wait_flag(output int t);
    bus_addr = 2'd0;
    forever begin
      @(negedge clk);
      #1;
      if (bus_rdata[7]) break;
    end
    t = cyc;
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic measure(input int code, input int cor, input string req);
    int t1, t2;
    wr(2'd0, ctrl_word(1'b0, 0, 0));
    wr(2'd2, 16'(cor));
    wr(2'd1, 16'd0);
    wr(2'd0, ctrl_word(1'b1, code, 0));
    wait_flag(t1);
    wr(2'd0, ctrl_word(1'b1, code, 0));
    wait_flag(t1);
    wr(2'd0, ctrl_word(1'b1, code, 0));
    wait_flag(t2);
    check(t2 - t1 == period_of(code, cor), req, t2 - t1, period_of(code, cor));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      report();
      $finish;
    end
  end

  initial begin
    logic [15:0] d, d2;
    int t, p;
    void'($urandom(32'd1751));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 reset state
    rd(2'd0, d); check(d == 16'h0, "R2 ctrl", d, 0);
    rd(2'd1, d); check(d == 16'h0, "R2 count", d, 0);
    rd(2'd2, d); check(d == 16'h0, "R2 const", d, 0);
    check(irq == 1'b0, "R2 irq", irq, 0);
    repeat (50) @(negedge clk);
    rd(2'd1, d); check(d == 16'h0, "R2 idle count", d, 0);

    // R1 reserved bits; writing 1 to bit 7 does not set the flag (R6)
    wr(2'd0, 16'hFFFF);
    rd(2'd0, d); check(d == 16'h007F, "R1 ctrl reserved / R6 write one", d, 16'h7F);
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'hFFAB);
    rd(2'd2, d); check(d == 16'h00AB, "R1 const upper", d, 16'hAB);
    wr(2'd1, 16'h1234);
    rd(2'd1, d); check(d == 16'h0034, "R1 R10 count write", d, 16'h34);
    rd(2'd3, d); check(d == 16'h0000, "R10 unmapped", d, 0);

    // R9 low storage
    wr(2'd0, 16'h0005);
    rd(2'd0, d); check(d == 16'h0005, "R9 low bits", d, 5);
    wr(2'd0, 16'h0002);
    rd(2'd0, d); check(d == 16'h0002, "R9 low bits 2", d, 2);

    // R4 stop code holds count
    wr(2'd0, 16'h0000);
    rd(2'd1, d);
    repeat (300) @(negedge clk);
    rd(2'd1, d2); check(d2 == d, "R4 stopped", d2, d);

    // R3 directed and random periods
    measure(1, 0, "R3 div4 const0");
    measure(1, 5, "R3 div4 const5");
    measure(2, 3, "R3 div16 const3");
    for (int i = 0; i < 6; i++) begin
      int c, k;
      c = 1 + int'($urandom % 3);
      k = int'($urandom % 12);
      measure(c, k, "R3 random");
    end

    // R5 sticky, R8 gating
    wr(2'd0, ctrl_word(1'b0, 1, 0));
    wait_flag(t);
    wr(2'd0, ctrl_word(1'b0, 0, 0) | 16'h0080);
    repeat (20) @(negedge clk);
    rd(2'd0, d); check(d[7] == 1'b1, "R5 sticky", d[7], 1);
    check(irq == 1'b0, "R8 irq masked", irq, 0);
    wr(2'd0, ctrl_word(1'b1, 0, 0) | 16'h0080);
    #1; check(irq == 1'b1, "R8 irq enabled", irq, 1);
    rd(2'd0, d); check(d[7] == 1'b1, "R6 write one keeps", d[7], 1);
    wr(2'd0, ctrl_word(1'b1, 0, 0));
    rd(2'd0, d); check(d[7] == 1'b0, "R6 clear", d[7], 0);
    #1; check(irq == 1'b0, "R8 irq after clear", irq, 0);

    // R7 set and clear on the same edge
    wr(2'd2, 16'd3);
    wr(2'd1, 16'd0);
    wr(2'd0, ctrl_word(1'b0, 1, 0));
    wait_flag(t);
    p = period_of(1, 3);
    repeat (p - 1) @(negedge clk);
    bus_addr = 2'd0; bus_we = 1'b1; bus_wdata = ctrl_word(1'b0, 1, 0);
    @(negedge clk);
    bus_we = 1'b0;
    rd(2'd0, d); check(d[7] == 1'b1, "R7 set wins", d[7], 1);
    // control: a clear away from a set edge takes effect
    wr(2'd0, ctrl_word(1'b0, 1, 0));
    rd(2'd0, d); check(d[7] == 1'b0, "R7 control clear", d[7], 0);

    done = 1'b1;
    report();
    $finish;
  end
endmodule